// File: doc/BRIEF.md
# Management Indirect Register Bridge

This block lets a single management-bus slave address reach up to 32 internal register sets. A host drives a simple parallel management port: a bus address, a register address, write data, and one-cycle read or write strobes. The block answers with a one-cycle `mb_done` pulse and, for reads, `mb_rdata`. Internally it masters a device register bus addressed by device number and register number. That bus uses a request/acknowledge handshake.

The `strap_addr` input picks the mode. When it is zero, the chip is alone on the bus. Every strobe is passed straight through: the bus address becomes the device number and the register address becomes the register number. When it is non-zero, the block answers only at that address and exposes two registers. Register 0 holds the command word and register 1 holds the data word. The host puts write data into the data register and then writes a command word with its start bit set. It polls bit 15 of the command register until that bit drops. After a read command, the host collects the fetched value from the data register.

Command word layout, from bit 15 down:
- bit 15: busy/start
- bit 12: clause-22 marker
- bits 11:10: opcode, with 2'b10 for read and 2'b01 for write
- bits 9:5: target device
- bits 4:0: target register

Top module: `mgmt_indirect_bridge`

## Requirements
- R1: After reset, `mb_done` and `dv_req` are low, and in multichip mode both the command register and the data register read 0.
- R2: With `strap_addr` non-zero, a strobe whose `mb_addr` differs from `strap_addr` produces no `mb_done` and changes no register.
- R3: In multichip mode, a read of register 0 returns the command word, a read of register 1 returns the data word, and a read of any other register returns 0.
- R4: A command write with bit 15 = 1, bit 12 = 1 and opcode 2'b10 (read) or 2'b01 (write) raises `dv_req`. The request carries device = bits 9:5, register = bits 4:0, and `dv_we` = 1 only for opcode 2'b01.
- R5: An indirect write sends to the device the value that was in the data register when the command was written.
- R6: When an indirect read is acknowledged, the data register takes `dv_rdata` and bit 15 of the command register clears.
- R7: While an indirect operation is in flight, a read of register 0 returns the stored command word with bit 15 high. Bit 15 stays high until the acknowledge.
- R8: While bit 15 is high, writes to the command register and to the data register are ignored.
- R9: A command write with bit 15 low, bit 12 low, or an opcode other than 2'b10 or 2'b01 starts no device access. The word is stored and reads back with bit 15 low.
- R10: With `strap_addr` = 0, any strobe starts a device access with device = `mb_addr` and register = `mb_reg`. One cycle after the acknowledge, `mb_done` pulses, and for a read `mb_rdata` equals the device's `dv_rdata`.
- R11: `dv_req` and its address, direction and write-data fields hold steady until `dv_ack`. In direct mode, strobes that arrive while an access is pending are ignored.
- R12: In multichip mode, an accepted strobe produces `mb_done` exactly one cycle later. If both strobes are high, the write wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_addr | input | 5 | Chip address strap; 0 selects single-chip direct mode |
| mb_addr | input | 5 | Management bus address |
| mb_reg | input | 5 | Management register address |
| mb_wdata | input | 16 | Management write data |
| mb_wr | input | 1 | Write strobe, one cycle |
| mb_rd | input | 1 | Read strobe, one cycle |
| mb_rdata | output | 16 | Read data, valid with `mb_done` after a read |
| mb_done | output | 1 | One-cycle completion pulse |
| dv_req | output | 1 | Internal access request, held until acknowledge |
| dv_we | output | 1 | Internal access direction, 1 = write |
| dv_dev | output | 5 | Internal target device |
| dv_reg | output | 5 | Internal target register |
| dv_wdata | output | 16 | Internal write data |
| dv_ack | input | 1 | Internal access acknowledge |
| dv_rdata | input | 16 | Internal read data, valid with `dv_ack` |

## Verification
On every cycle, assertions check the following:
- the request and its fields hold steady until acknowledge;
- a request only rises after a strobe;
- its device field comes from the command word or from the bus address, depending on mode;
- busy only falls on an acknowledge;
- a completion pulse always follows a strobe or an acknowledge.

Only the bench's scenarios can show the data-flow properties: write data taken from the data register, read data landing in it, and command and data writes being ignored while busy. The same holds for malformed commands reading back idle, foreign bus addresses drawing no answer, and the direct-mode pass-through returning the device's contents. The bench shows these by comparing against a behavioural model every clock while the acknowledge latency is varied.

// File: rtl/mgmt_indirect_bridge.sv
module mgmt_indirect_bridge #(
  parameter int AW = 5,
  parameter int RW = 5,
  parameter int CMD_REG = 0,
  parameter int DATA_REG = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] strap_addr,
  input  logic [AW-1:0] mb_addr,
  input  logic [RW-1:0] mb_reg,
  input  logic [15:0]   mb_wdata,
  input  logic          mb_wr,
  input  logic          mb_rd,
  output logic [15:0]   mb_rdata,
  output logic          mb_done,
  output logic          dv_req,
  output logic          dv_we,
  output logic [4:0]    dv_dev,
  output logic [4:0]    dv_reg,
  output logic [15:0]   dv_wdata,
  input  logic          dv_ack,
  input  logic [15:0]   dv_rdata
);
  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  logic        busy, dir_pend;
  logic [14:0] cmd_q;
  logic [15:0] data_q;

  wire direct   = (strap_addr == '0);
  wire strobe   = mb_wr | mb_rd;
  wire hit      = strobe & ~direct & (mb_addr == strap_addr);
  wire take_dir = strobe & direct & ~dir_pend;
  wire ack_take = dv_req & dv_ack;
  wire [1:0] op = mb_wdata[11:10];
  wire cmd_ok   = mb_wdata[15] & mb_wdata[12] & ((op == OP_RD) | (op == OP_WR));
  wire cmd_wr   = hit & mb_wr & (mb_reg == RW'(CMD_REG)) & ~busy;
  wire data_wr  = hit & mb_wr & (mb_reg == RW'(DATA_REG)) & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; dir_pend <= 1'b0; cmd_q <= '0; data_q <= '0;
      mb_rdata <= '0; mb_done <= 1'b0;
      dv_req <= 1'b0; dv_we <= 1'b0; dv_dev <= '0; dv_reg <= '0; dv_wdata <= '0;
    end else begin
      mb_done <= 1'b0;
      if (ack_take) begin
        dv_req <= 1'b0;
        if (dir_pend) begin
          dir_pend <= 1'b0;
          mb_done  <= 1'b1;
          if (!dv_we) mb_rdata <= dv_rdata;
        end else begin
          busy <= 1'b0;
          if (!dv_we) data_q <= dv_rdata;
        end
      end
      if (take_dir) begin
        dir_pend <= 1'b1;
        dv_req   <= 1'b1;
        dv_we    <= mb_wr;
        dv_dev   <= 5'(mb_addr);
        dv_reg   <= 5'(mb_reg);
        dv_wdata <= mb_wdata;
      end
      if (hit) begin
        mb_done <= 1'b1;
        if (!mb_wr) begin
          if (mb_reg == RW'(CMD_REG))       mb_rdata <= {busy, cmd_q};
          else if (mb_reg == RW'(DATA_REG)) mb_rdata <= data_q;
          else                              mb_rdata <= '0;
        end
      end
      if (data_wr) data_q <= mb_wdata;
      if (cmd_wr) begin
        cmd_q <= mb_wdata[14:0];
        if (cmd_ok) begin
          busy     <= 1'b1;
          dv_req   <= 1'b1;
          dv_we    <= (op == OP_WR);
          dv_dev   <= mb_wdata[9:5];
          dv_reg   <= mb_wdata[4:0];
          dv_wdata <= data_q;
        end
      end
    end
  end

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dv_req && !dv_ack |=> dv_req && $stable(dv_dev) && $stable(dv_reg)
                          && $stable(dv_we) && $stable(dv_wdata));

  a_r4_req_from_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dv_req) |-> $past(mb_wr || mb_rd));

  a_r4_dev_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dv_req) && busy |-> dv_dev == $past(mb_wdata[9:5]) && dv_reg == $past(mb_wdata[4:0]));

  a_r10_dev_from_bus: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dv_req) && dir_pend |-> dv_dev == 5'($past(mb_addr)) && dv_reg == 5'($past(mb_reg)));

  a_r7_busy_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(dv_req && dv_ack));

  a_r12_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    mb_done |-> $past(mb_wr || mb_rd || (dv_req && dv_ack)));
endmodule

// File: tb/mgmt_indirect_bridge_bench.sv
module mgmt_indirect_bridge_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] strap_addr = 5'd3, mb_addr = '0, mb_reg = '0;
  logic [15:0] mb_wdata = '0;
  logic mb_wr = 1'b0, mb_rd = 1'b0;
  logic [15:0] mb_rdata;
  logic mb_done, dv_req, dv_we;
  logic [4:0] dv_dev, dv_reg;
  logic [15:0] dv_wdata;
  logic dv_ack = 1'b0;
  logic [15:0] dv_rdata = '0;

  mgmt_indirect_bridge u_mgmt_indirect_bridge (
    .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr),
    .mb_addr(mb_addr), .mb_reg(mb_reg), .mb_wdata(mb_wdata),
    .mb_wr(mb_wr), .mb_rd(mb_rd), .mb_rdata(mb_rdata), .mb_done(mb_done),
    .dv_req(dv_req), .dv_we(dv_we), .dv_dev(dv_dev), .dv_reg(dv_reg),
    .dv_wdata(dv_wdata), .dv_ack(dv_ack), .dv_rdata(dv_rdata));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, lat = 0;
  bit wd_hit = 0;
  logic [15:0] mem [0:1023];

  bit m_busy, m_dpend, m_req, m_we, m_done, m_rdchk;
  logic [14:0] m_cmd;
  logic [15:0] m_data, m_rdata, m_wd;
  logic [4:0] m_dev, m_reg;
  int m_cnt;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    dv_ack   <= m_req && (m_cnt >= lat);
    dv_rdata <= mem[{m_dev, m_reg}];
  end

  always @(posedge clk) begin
    bit b0, p0; logic [14:0] c0; logic [15:0] d0; logic [1:0] op;
    if (!rst_n) begin
      m_busy = 0; m_dpend = 0; m_req = 0; m_we = 0; m_done = 0; m_rdchk = 0;
      m_cmd = '0; m_data = '0; m_rdata = '0; m_wd = '0; m_dev = '0; m_reg = '0; m_cnt = 0;
    end else begin
      b0 = m_busy; p0 = m_dpend; c0 = m_cmd; d0 = m_data;
      m_done = 0;
      if (m_req && dv_ack) begin
        m_req = 0;
        if (m_we) mem[{m_dev, m_reg}] = m_wd;
        if (p0) begin
          m_dpend = 0; m_done = 1; m_rdchk = !m_we;
          if (!m_we) m_rdata = dv_rdata;
        end else begin
          m_busy = 0;
          if (!m_we) m_data = dv_rdata;
        end
      end else if (m_req) m_cnt++;
      if (mb_wr || mb_rd) begin
        if (strap_addr == 0) begin
          if (!p0) begin
            m_req = 1; m_dpend = 1; m_we = mb_wr; m_dev = mb_addr; m_reg = mb_reg;
            m_wd = mb_wdata; m_cnt = 0;
          end
        end else if (mb_addr == strap_addr) begin
          m_done = 1; m_rdchk = !mb_wr;
          if (mb_wr) begin
            if (mb_reg == 0 && !b0) begin
              op = mb_wdata[11:10];
              m_cmd = mb_wdata[14:0];
              if (mb_wdata[15] && mb_wdata[12] && (op == 2'b10 || op == 2'b01)) begin
                m_busy = 1; m_req = 1; m_we = (op == 2'b01); m_dev = mb_wdata[9:5];
                m_reg = mb_wdata[4:0]; m_wd = d0; m_cnt = 0;
              end
            end else if (mb_reg == 1 && !b0) m_data = mb_wdata;
          end else begin
            m_rdata = (mb_reg == 0) ? {b0, c0} : (mb_reg == 1) ? d0 : 16'h0;
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    #5;
    if (rst_n && !wd_hit) begin
      chk(mb_done === m_done, "R12 done", 32'(mb_done), 32'(m_done));
      if (m_done && m_rdchk) chk(mb_rdata === m_rdata, "R3 rdata", 32'(mb_rdata), 32'(m_rdata));
      chk(dv_req === m_req, "R11 req", 32'(dv_req), 32'(m_req));
      if (m_req) begin
        chk({dv_we, dv_dev, dv_reg} === {m_we, m_dev, m_reg}, "R4 fields",
            32'({dv_we, dv_dev, dv_reg}), 32'({m_we, m_dev, m_reg}));
        if (m_we) chk(dv_wdata === m_wd, "R5 wdata", 32'(dv_wdata), 32'(m_wd));
      end
    end
  end

  task automatic access(input logic [4:0] a, input logic [4:0] r, input logic [15:0] d,
                        input bit w, input int maxw, output bit got, output logic [15:0] val);
    @(negedge clk);
    mb_addr = a; mb_reg = r; mb_wdata = d; mb_wr = w; mb_rd = !w;
    @(posedge clk); #5;
    mb_wr = 0; mb_rd = 0;
    got = 0; val = '0;
    for (int i = 0; i < maxw; i++) begin
      if (mb_done) begin got = 1; val = mb_rdata; break; end
      @(posedge clk); #5;
    end
  endtask

  task automatic poll_idle();
    bit g; logic [15:0] v;
    for (int i = 0; i < 50; i++) begin
      access(strap_addr, 0, 0, 0, 2, g, v);
      if (!v[15]) break;
    end
  endtask

  initial begin
    #(20 * 150000);
    wd_hit = 1;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit g; logic [15:0] v;
    for (int i = 0; i < 1024; i++) mem[i] = 16'(i * 3);
    mem[{5'd7, 5'd9}] = 16'hBEEF;
    mem[{5'd12, 5'd3}] = 16'hA5A5;
    mem[{5'd1, 5'd1}] = 16'h0000;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #5;
    chk(!mb_done && !dv_req, "R1 idle", 32'({mb_done, dv_req}), 0);
    access(3, 0, 0, 0, 2, g, v); chk(g && v == 0, "R1 cmd", 32'(v), 0);
    access(3, 1, 0, 0, 2, g, v); chk(g && v == 0, "R1 data", 32'(v), 0);
    access(4, 1, 16'h4444, 1, 3, g, v); chk(!g, "R2 no answer", 32'(g), 0);
    access(3, 1, 0, 0, 2, g, v); chk(v == 0, "R2 data untouched", 32'(v), 0);
    access(3, 5, 0, 0, 2, g, v); chk(v == 0, "R3 other reg", 32'(v), 0);
    lat = 3;
    access(3, 0, 16'h98E9, 1, 2, g, v); chk(g, "R12 write done", 32'(g), 1);
    access(3, 0, 0, 0, 2, g, v); chk(v == 16'h98E9, "R7 busy readback", 32'(v), 32'h98E9);
    poll_idle();
    access(3, 1, 0, 0, 2, g, v); chk(v == 16'hBEEF, "R6 read data", 32'(v), 32'hBEEF);
    access(3, 0, 0, 0, 2, g, v); chk(v == 16'h18E9, "R6 busy cleared", 32'(v), 32'h18E9);
    access(3, 1, 16'h1234, 1, 2, g, v);
    access(3, 0, 16'h9445, 1, 2, g, v);
    access(3, 1, 16'h5555, 1, 2, g, v);
    access(3, 0, 16'h98E9, 1, 2, g, v);
    poll_idle();
    chk(mem[{5'd2, 5'd5}] == 16'h1234, "R5 write value", 32'(mem[{5'd2, 5'd5}]), 32'h1234);
    access(3, 1, 0, 0, 2, g, v); chk(v == 16'h1234, "R8 data kept", 32'(v), 32'h1234);
    access(3, 0, 0, 0, 2, g, v); chk(v == 16'h1445, "R8 cmd kept", 32'(v), 32'h1445);
    access(3, 0, 16'h18E9, 1, 2, g, v);
    access(3, 0, 0, 0, 2, g, v); chk(v == 16'h18E9 && !dv_req, "R9 no start bit", 32'(v), 32'h18E9);
    access(3, 0, 16'h9CE9, 1, 2, g, v);
    access(3, 0, 0, 0, 2, g, v); chk(v == 16'h1CE9 && !dv_req, "R9 bad opcode", 32'(v), 32'h1CE9);
    access(3, 0, 16'h88E9, 1, 2, g, v);
    access(3, 0, 0, 0, 2, g, v); chk(v == 16'h08E9 && !dv_req, "R9 no clause bit", 32'(v), 32'h08E9);
    access(3, 1, 0, 0, 2, g, v); chk(v == 16'h1234, "R9 data kept", 32'(v), 32'h1234);
    @(negedge clk); mb_addr = 3; mb_reg = 1; mb_wdata = 16'h0777; mb_wr = 1; mb_rd = 1;
    @(negedge clk); mb_wr = 0; mb_rd = 0;
    access(3, 1, 0, 0, 2, g, v); chk(v == 16'h0777, "R12 write wins", 32'(v), 32'h0777);
    strap_addr = 0; lat = 2;
    access(12, 3, 0, 0, 10, g, v); chk(g && v == 16'hA5A5, "R10 direct read", 32'(v), 32'hA5A5);
    lat = 0;
    access(30, 31, 16'h0F0F, 1, 10, g, v);
    chk(g && mem[{5'd30, 5'd31}] == 16'h0F0F, "R10 direct write", 32'(mem[{5'd30, 5'd31}]), 32'h0F0F);
    lat = 4;
    @(negedge clk); mb_addr = 12; mb_reg = 3; mb_rd = 1;
    @(negedge clk); mb_rd = 0; mb_addr = 1; mb_reg = 1; mb_wdata = 16'h7777; mb_wr = 1;
    @(negedge clk); mb_wr = 0;
    repeat (10) @(negedge clk);
    chk(mem[{5'd1, 5'd1}] == 16'h0000, "R11 pending strobe ignored", 32'(mem[{5'd1, 5'd1}]), 0);
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule